// File: doc/BRIEF.md
# Sample-Tick Timer Interrupt Controller

This block holds three 8-bit timers, called A, B and C, that advance on a once-per-audio-sample tick strobe. Each timer has its own 3-bit prescaler: a larger prescaler makes the timer count more slowly. When a timer runs out, it latches a bit in a shared pending register. Software programs a timer by writing a start value and a prescaler. It masks sources with an enable register and drops serviced requests through a write-one-to-clear register.

The enabled pending timers compete with a "received byte waiting" flag from an external serial-music input queue. The winner drives a single interrupt request. Three level registers supply the request's 3-bit priority level. Each level register gives one bit of the level, taken at a bit position that is fixed per source.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset every timer reads 0x00FF, with prescaler 0 and upper count byte 0xFF, and its internal count is 0xFFFF. Pending, enable and all three level registers read 0, and `irq_req` is low.
- R2: A write to a timer address loads the prescaler from bits 10:8 and the start value from bits 7:0. The start value goes into the upper byte of a 16-bit count, and the lower byte is cleared. Reading that address returns {5'b0, prescaler, upper count byte}. The timer addresses are 0 for A, 1 for B and 2 for C.
- R3: Each cycle with `tick` high adds 2^(8 − prescaler) to a timer's count, but only while the count is at most 0xFF00. At any other count the tick has no effect.
- R4: When an addition gives a result of 0xFF00 or more, the count becomes 0xFFFF on the same clock edge. The timer's pending bit is also set on that edge: bit 6 for A, bit 7 for B, bit 8 for C, read at address 4.
- R5: A write to address 5 clears each pending bit that is written as one. On the same edge, every timer whose count is at or above 0xFF00 sets its pending bit again. Address 5 reads as 0. Writes to address 4 have no effect.
- R6: The enable register at address 3 uses bits 8:6. A pending timer whose enable bit is 0 does not raise `irq_req`.
- R7: Priority is fixed: the received-byte flag first, then A, then B, then C. `irq_level` follows the highest-priority active source.
- R8: The level registers sit at addresses 6, 7 and 8. They supply level bits 0, 1 and 2. Each source reads its level bit at a fixed position: bit 3 for the received-byte flag, bit 6 for A, and bit 7 for both B and C.
- R9: `irq_req` stays high while any enabled pending bit or the received-byte flag remains. It falls once these are all cleared.
- R10: If a timer load and a tick fall in the same cycle, the load wins. If a clear write and a timer expiry fall in the same cycle, the expiry wins and the pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe per audio sample |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data for `addr` |
| midi_rx_avail | input | 1 | Serial-music input queue holds a byte |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Level of the winning source |

## Verification
The bench uses the default widths: a 16-bit bus, 4-bit addresses and 8-bit level registers. With these, the full expiry path is short enough to test directly. Prescaler 2 from start 0xFC is checked one tick before and one tick after it runs out. Prescaler 0 is used from 0xF0, and prescaler 7 is used from 0xFF, which sits exactly on the 0xFF00 limit. Distinct level patterns at bits 3, 6 and 7 make each source's level visible. Same-cycle load/tick and clear/expiry collisions are driven explicitly.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int CNT_W   = 16;
  localparam int HI_W    = CNT_W / 2;
  localparam int PRE_W   = 3;
  localparam int NUM_TMR = 3;
  localparam int LVL_BITS = 3;

  // pending/enable field position and per-source level bit positions
  localparam int PEND_LSB     = 6;
  localparam int LVLPOS_MIDI  = 3;
  localparam int LVLPOS_TA    = 6;
  localparam int LVLPOS_TBC   = 7;

  // register addresses
  localparam int ADR_TMR0 = 0;
  localparam int ADR_EN   = 3;
  localparam int ADR_PEND = 4;
  localparam int ADR_CLR  = 5;
  localparam int ADR_LVL0 = 6;

  localparam logic [CNT_W-1:0] RUN_LIMIT = {{HI_W{1'b1}}, {HI_W{1'b0}}};
  localparam logic [CNT_W-1:0] CNT_FULL  = {CNT_W{1'b1}};

  typedef enum logic [2:0] {SRC_NONE, SRC_MIDI, SRC_TA, SRC_TB, SRC_TC} irq_src_e;

  // one tick: count + 2^(HI_W - prescaler), one bit wider to keep the carry
  function automatic logic [CNT_W:0] tmr_advance(input logic [CNT_W-1:0] c,
                                                 input logic [PRE_W-1:0] p);
    int sh;
    sh = HI_W - int'(p);
    return {1'b0, c} + ((CNT_W+1)'(1) << sh);
  endfunction

  function automatic logic [LVL_BITS-1:0] level_at(input logic [7:0] l0,
                                                   input logic [7:0] l1,
                                                   input logic [7:0] l2,
                                                   input int pos);
    return {l2[pos], l1[pos], l0[pos]};
  endfunction
endpackage

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [PRE_W-1:0] load_pre,
  input  logic [HI_W-1:0]  load_start,
  output logic [CNT_W-1:0] count,
  output logic [PRE_W-1:0] presc,
  output logic             expire_evt,
  output logic             expired
);
  logic             running;
  logic [CNT_W:0]   stepped;
  logic             crossing;

  always_comb begin
    running    = (count <= RUN_LIMIT);
    stepped    = tmr_advance(count, presc);
    crossing   = (stepped >= {1'b0, RUN_LIMIT});
    expire_evt = tick && !load && running && crossing;
    expired    = (count >= RUN_LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= CNT_FULL;
      presc <= '0;
    end else if (load) begin
      presc <= load_pre;
      count <= {load_start, {HI_W{1'b0}}};
    end else if (tick && running) begin
      count <= crossing ? CNT_FULL : stepped[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import tmr_irq_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic                midi_rx_avail,
  input  logic [NUM_TMR-1:0]  active,
  input  logic [LVL_W-1:0]    lvl0,
  input  logic [LVL_W-1:0]    lvl1,
  input  logic [LVL_W-1:0]    lvl2,
  output logic                irq_req,
  output logic [LVL_BITS-1:0] irq_level,
  output irq_src_e            src
);
  logic [7:0] l0, l1, l2;

  always_comb begin
    l0 = 8'(lvl0);
    l1 = 8'(lvl1);
    l2 = 8'(lvl2);
    src       = SRC_NONE;
    irq_level = '0;
    if (midi_rx_avail) begin
      src       = SRC_MIDI;
      irq_level = level_at(l0, l1, l2, LVLPOS_MIDI);
    end else if (active[0]) begin
      src       = SRC_TA;
      irq_level = level_at(l0, l1, l2, LVLPOS_TA);
    end else if (active[1]) begin
      src       = SRC_TB;
      irq_level = level_at(l0, l1, l2, LVLPOS_TBC);
    end else if (active[2]) begin
      src       = SRC_TC;
      irq_level = level_at(l0, l1, l2, LVLPOS_TBC);
    end
    irq_req = (src != SRC_NONE);
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int LVL_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                midi_rx_avail,
  output logic                irq_req,
  output logic [2:0]          irq_level
);
  localparam int NUM_LVL = LVL_BITS;

  logic [CNT_W-1:0]         cnt   [NUM_TMR];
  logic [PRE_W-1:0]         presc [NUM_TMR];
  logic [NUM_TMR-1:0]       ld;
  logic [NUM_TMR-1:0]       expire_evt;
  logic [NUM_TMR-1:0]       expired;
  logic [NUM_TMR-1:0]       pend_q, en_q;
  logic [LVL_W-1:0]         lvl_q [NUM_LVL];
  logic [NUM_TMR*CNT_W-1:0] cnt_flat;
  logic [NUM_LVL*LVL_W-1:0] lvl_flat;
  logic                     clr_wr;
  logic [NUM_TMR-1:0]       clr_mask;
  logic [NUM_TMR-1:0]       pend_next;
  irq_src_e                 src;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    assign ld[i] = wr_en && (addr == ADDR_W'(ADR_TMR0 + i));
    assign cnt_flat[i*CNT_W +: CNT_W] = cnt[i];
    tmr_unit u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .load       (ld[i]),
      .load_pre   (wr_data[HI_W +: PRE_W]),
      .load_start (wr_data[HI_W-1:0]),
      .count      (cnt[i]),
      .presc      (presc[i]),
      .expire_evt (expire_evt[i]),
      .expired    (expired[i])
    );
  end

  assign clr_wr   = wr_en && (addr == ADDR_W'(ADR_CLR));
  assign clr_mask = wr_data[PEND_LSB +: NUM_TMR];

  // expired timers re-arm on any clear write; a fresh expiry always wins
  always_comb begin
    pend_next = pend_q;
    if (clr_wr) pend_next = (pend_q & ~clr_mask) | expired;
    pend_next = pend_next | expire_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_next;
      if (wr_en && addr == ADDR_W'(ADR_EN)) en_q <= wr_data[PEND_LSB +: NUM_TMR];
    end
  end

  for (genvar j = 0; j < NUM_LVL; j++) begin : g_lvl
    assign lvl_flat[j*LVL_W +: LVL_W] = lvl_q[j];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[j] <= '0;
      else if (wr_en && addr == ADDR_W'(ADR_LVL0 + j)) lvl_q[j] <= wr_data[LVL_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_TMR; i++)
      if (addr == ADDR_W'(ADR_TMR0 + i))
        rd_data = DATA_W'({presc[i], cnt[i][CNT_W-1:HI_W]});
    if (addr == ADDR_W'(ADR_EN))   rd_data = DATA_W'({en_q, {PEND_LSB{1'b0}}});
    if (addr == ADDR_W'(ADR_PEND)) rd_data = DATA_W'({pend_q, {PEND_LSB{1'b0}}});
    for (int j = 0; j < NUM_LVL; j++)
      if (addr == ADDR_W'(ADR_LVL0 + j)) rd_data = DATA_W'(lvl_q[j]);
  end

  irq_arb #(.LVL_W(LVL_W)) u_arb (
    .midi_rx_avail (midi_rx_avail),
    .active        (pend_q & en_q),
    .lvl0          (lvl_q[0]),
    .lvl1          (lvl_q[1]),
    .lvl2          (lvl_q[2]),
    .irq_req       (irq_req),
    .irq_level     (irq_level),
    .src           (src)
  );
endmodule

// File: rtl/tmr_irq_chk.sv
module tmr_irq_chk
  import tmr_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int LVL_W  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        addr,
  input logic                     midi_rx_avail,
  input logic                     irq_req,
  input logic [2:0]               irq_level,
  input logic [NUM_TMR*CNT_W-1:0] cnt_flat,
  input logic [NUM_TMR-1:0]       ld,
  input logic [NUM_TMR-1:0]       expire_evt,
  input logic [NUM_TMR-1:0]       pend_q,
  input logic [NUM_TMR-1:0]       en_q,
  input logic [3*LVL_W-1:0]       lvl_flat
);
  logic clr_wr;
  assign clr_wr = wr_en && (addr == ADDR_W'(ADR_CLR));

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_t
    a_r3_no_backstep: assert property (@(posedge clk) disable iff (!rst_n)
      !ld[i] |=> cnt_flat[i*CNT_W +: CNT_W] >= $past(cnt_flat[i*CNT_W +: CNT_W]));
    a_r4_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld[i] && cnt_flat[i*CNT_W +: CNT_W] == CNT_FULL) |=> cnt_flat[i*CNT_W +: CNT_W] == CNT_FULL);
    a_r4_expiry_pends: assert property (@(posedge clk) disable iff (!rst_n)
      expire_evt[i] |=> pend_q[i]);
    a_r5_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && cnt_flat[i*CNT_W +: CNT_W] >= RUN_LIMIT) |=> pend_q[i]);
  end

  a_r7_midi_first: assert property (@(posedge clk) disable iff (!rst_n)
    midi_rx_avail |-> (irq_req && irq_level ==
      {lvl_flat[2*LVL_W + LVLPOS_MIDI], lvl_flat[LVL_W + LVLPOS_MIDI], lvl_flat[LVLPOS_MIDI]}));
  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!midi_rx_avail && (pend_q & en_q) == '0) |-> !irq_req);
endmodule

bind tmr_irq_ctrl tmr_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .addr          (addr),
  .midi_rx_avail (midi_rx_avail),
  .irq_req       (irq_req),
  .irq_level     (irq_level),
  .cnt_flat      (cnt_flat),
  .ld            (ld),
  .expire_evt    (expire_evt),
  .pend_q        (pend_q),
  .en_q          (en_q),
  .lvl_flat      (lvl_flat)
);

// File: tb/sim_tmr_irq_ctrl.sv
module sim_tmr_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        midi = 1'b0;
  logic        irq_req;
  logic [2:0]  irq_level;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .midi_rx_avail(midi),
    .irq_req(irq_req), .irq_level(irq_level)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, string req, logic [15:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic irq_is(string req, logic r, logic [2:0] lv);
    #1;
    chk(req, {12'h0, irq_req, lv & {3{r}}}, {12'h0, r, lv & {3{r}}});
    if (r) chk(req, {13'h0, irq_level}, {13'h0, lv});
  endtask

  task automatic t_reset;
    for (int i = 0; i < 3; i++) rd(4'(i), "R1 timer", 16'h00FF);
    rd(4'd3, "R1 enable", 16'h0000);
    rd(4'd4, "R1 pending", 16'h0000);
    for (int j = 6; j < 9; j++) rd(4'(j), "R1 level", 16'h0000);
    irq_is("R1 irq", 1'b0, 3'd0);
  endtask

  task automatic t_count;
    wr(4'd0, 16'h02FC);
    rd(4'd0, "R2 readback", 16'h02FC);
    ticks(11);
    rd(4'd0, "R3 before expiry", 16'h02FE);
    rd(4'd4, "R4 not yet pending", 16'h0000);
    ticks(1);
    rd(4'd0, "R4 full", 16'h02FF);
    rd(4'd4, "R4 pend A", 16'h0040);
    ticks(3);
    rd(4'd0, "R3 no count past limit", 16'h02FF);
  endtask

  task automatic t_presc;
    wr(4'd1, 16'h00F0);
    ticks(14);
    rd(4'd1, "R3 presc0 step", 16'h00FE);
    ticks(1);
    rd(4'd1, "R4 B full", 16'h00FF);
    rd(4'd4, "R4 pend B", 16'h00C0);
    wr(4'd2, 16'h07FF);
    rd(4'd2, "R2 C readback", 16'h07FF);
    ticks(1);
    rd(4'd4, "R4 C at limit", 16'h01C0);
  endtask

  task automatic t_clear;
    wr(4'd0, 16'h0000);
    wr(4'd5, 16'h01C0);
    rd(4'd4, "R5 rearm B C", 16'h0180);
    wr(4'd4, 16'h0000);
    rd(4'd4, "R5 pending write ignored", 16'h0180);
    rd(4'd5, "R5 clear reads zero", 16'h0000);
    wr(4'd1, 16'h0000);
    wr(4'd2, 16'h0000);
    wr(4'd5, 16'h0180);
    rd(4'd4, "R5 all clear", 16'h0000);
  endtask

  task automatic t_irq;
    wr(4'd6, 16'h0048);
    wr(4'd7, 16'h0088);
    wr(4'd8, 16'h0008);
    wr(4'd0, 16'h00FF);
    ticks(1);
    rd(4'd4, "R6 pend A", 16'h0040);
    irq_is("R6 masked", 1'b0, 3'd0);
    wr(4'd3, 16'h01C0);
    irq_is("R8 level A", 1'b1, 3'd1);
    @(negedge clk); midi = 1'b1;
    irq_is("R7 midi over A", 1'b1, 3'd7);
    @(negedge clk); midi = 1'b0;
    irq_is("R7 back to A", 1'b1, 3'd1);
    wr(4'd1, 16'h00FF);
    ticks(1);
    irq_is("R7 A over B", 1'b1, 3'd1);
    wr(4'd0, 16'h0000);
    wr(4'd5, 16'h0040);
    irq_is("R8 level B", 1'b1, 3'd2);
    repeat (5) @(negedge clk);
    irq_is("R9 held", 1'b1, 3'd2);
    wr(4'd1, 16'h0000);
    wr(4'd5, 16'h0080);
    irq_is("R9 drop", 1'b0, 3'd0);
    wr(4'd2, 16'h00FF);
    ticks(1);
    irq_is("R8 level C shared", 1'b1, 3'd2);
    wr(4'd2, 16'h0000);
    wr(4'd5, 16'h0100);
    rd(4'd4, "R5 C cleared", 16'h0000);
    @(negedge clk); midi = 1'b1;
    irq_is("R7 midi alone", 1'b1, 3'd7);
    @(negedge clk); midi = 1'b0;
    irq_is("R9 midi empty", 1'b0, 3'd0);
  endtask

  task automatic t_collide;
    @(negedge clk); wr_en = 1'b1; addr = 4'd0; wr_data = 16'h00FE; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    rd(4'd0, "R10 load beats tick", 16'h00FE);
    rd(4'd4, "R10 no pend", 16'h0000);
    @(negedge clk); wr_en = 1'b1; addr = 4'd5; wr_data = 16'h0040; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    rd(4'd4, "R10 expiry beats clear", 16'h0040);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_presc();
    t_clear();
    t_irq();
    t_collide();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule